// File: doc/BRIEF.md
# Programmable Header Parser

This block receives a packet one byte per cycle, with start-of-packet and end-of-packet markers, and turns its leading bytes into a header vector. The vector has a fixed set of 16-bit slots, a bitmap that shows which header types were found, an error flag and the arrival port. Which headers are recognised, in what order they may follow each other, and which bytes of each header land in which slot are all held in a graph table. The table is written at run time through a small configuration port, so the same logic can parse a plain Ethernet/IPv4/TCP frame, a frame carrying one or two stacked labels, or any other chain the table describes.

The bytes of each packet are kept in a window of WIN bytes. Once the last byte has been accepted, a walker visits one graph node per cycle, starting at node 0 at byte offset 0. For each node it checks that the whole header is inside the packet, writes the configured fields into their slots, reads a 1- or 2-byte selector, and looks it up in the node's match entries to find the next node. The next header always begins right where the current one ends. Stacked or inner copies of a header use separate nodes, and those nodes point at separate slots. When parsing ends, the vector is announced with a one-cycle strobe. While the walk runs, the input is held off.

Top module: `hdr_parser`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and out_vec, out_hdr_vld and out_err are all zero.
- R2: An accepted start-of-packet byte clears every slot, the header bitmap and the error flag, and captures in_port. Slots the new packet does not write therefore read zero.
- R3: Parsing starts at node 0, offset 0. A node with length L occupies bytes base..base+L-1, and the next node starts at base+L. An extraction entry copies the bytes at base+off into its slot, big-endian. With 1 byte the value is zero-extended; with 2 bytes the byte at base+off is the upper byte.
- R4: The selector is sel_bytes bytes at base+sel_off (a value of 0 means the node is terminal). It is compared with the node's enabled match entries, and the lowest-numbered equal entry gives the next node. If no entry matches, or the node is terminal, parsing ends without error.
- R5: Bit i of out_hdr_vld is set when node i was visited and its whole header fell inside the packet.
- R6: If base+L exceeds the packet length or WIN, out_err is 1, that node's slots are left untouched, its bitmap bit stays clear, and parsing ends.
- R7: out_valid is high for exactly one cycle. That cycle is n clock edges after the edge that accepted the end-of-packet byte, where n is the number of nodes visited (the failing node included).
- R8: in_ready is 0 from the edge that accepts end-of-packet until out_valid. Bytes offered while in_ready is 0 have no effect. in_ready is 1 again in the out_valid cycle.
- R9: One walk visits at most 2**NODE_IW nodes, so a graph that loops ends after that many nodes without error.
- R10: While in_ready is 1 and no start-of-packet is accepted, out_vec, out_hdr_vld and out_err hold their values.
- R11: Configuration is written with cfg_we, cfg_node and cfg_item, and takes effect for the next walk. The cfg_data layout depends on cfg_item:
  - item 0: length in [7:0], sel_off in [15:8], sel_bytes in [17:16];
  - items 1..4 (match entries 0..3): value in [15:0], next node in [18:16], enable in bit 31;
  - items 8..11 (extraction entries 0..3): off in [7:0], byte count in [9:8], slot in [19:16], enable in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_byte | input | 8 | Packet byte |
| in_port | input | PORT_W | Arrival port, sampled with the first byte |
| in_ready | output | 1 | Block can accept bytes |
| cfg_we | input | 1 | Graph table write strobe |
| cfg_node | input | NODE_IW | Node being written |
| cfg_item | input | 4 | Item within the node |
| cfg_data | input | 32 | Item contents |
| out_valid | output | 1 | One-cycle strobe: the vector is complete |
| out_err | output | 1 | A header was cut short |
| out_port | output | PORT_W | Arrival port of the packet |
| out_hdr_vld | output | 2**NODE_IW | Bitmap of headers found |
| out_vec | output | 16*2**SLOT_IW | Slot contents, slot k in bits 16k+15..16k |

## Verification
Each node takes one cycle, so the vector is due exactly n edges after the edge that accepted end-of-packet, where n is the number of nodes the walk visits. The bench works out n for every packet with its own walk of its own copy of the graph table. From that it records the cycle number at which the strobe must appear, and the monitor compares that number with the cycle in which out_valid is actually seen. The input is held off from the edge after end-of-packet, so the bench checks in_ready on the falling edge right after that edge, and offers a stray byte in the same cycle. The hold check samples the outputs several idle cycles after the strobe.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int NODE_IW = 3;
  localparam int SLOT_IW = 4;
  localparam int FIELD_W = 16;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] sel_off;
    logic [1:0] sel_bytes;
  } hp_node_t;

  typedef struct packed {
    logic               en;
    logic [NODE_IW-1:0] nxt;
    logic [FIELD_W-1:0] val;
  } hp_match_t;

  typedef struct packed {
    logic               en;
    logic [7:0]         off;
    logic [1:0]         nbytes;
    logic [SLOT_IW-1:0] slot;
  } hp_extr_t;

  function automatic hp_node_t word_to_node(input logic [31:0] d);
    return '{len: d[7:0], sel_off: d[15:8], sel_bytes: d[17:16]};
  endfunction

  function automatic hp_match_t word_to_match(input logic [31:0] d);
    return '{en: d[31], nxt: d[16+:NODE_IW], val: d[15:0]};
  endfunction

  function automatic hp_extr_t word_to_extr(input logic [31:0] d);
    return '{en: d[31], off: d[7:0], nbytes: d[9:8], slot: d[16+:SLOT_IW]};
  endfunction
endpackage

// File: rtl/hp_byte_window.sv
module hp_byte_window #(
  parameter int WIN   = 64,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sop,
  input  logic [7:0]       din,
  output logic [WIN*8-1:0] win_flat,
  output logic [LEN_W-1:0] pkt_len
);
  localparam int IDX_W = $clog2(WIN);

  logic [7:0] bytes_q [WIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) bytes_q[i] <= '0;
      pkt_len <= '0;
    end else if (take) begin
      if (sop) begin
        for (int i = 0; i < WIN; i++) bytes_q[i] <= (i == 0) ? din : 8'h00;
        pkt_len <= LEN_W'(1);
      end else begin
        if (pkt_len < LEN_W'(WIN)) bytes_q[pkt_len[IDX_W-1:0]] <= din;
        if (pkt_len != '1) pkt_len <= pkt_len + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < WIN; g++) begin : g_flat
    assign win_flat[g*8 +: 8] = bytes_q[g];
  end
endmodule

// File: rtl/hp_graph_table.sv
module hp_graph_table
  import hp_pkg::*;
#(
  parameter int MATCHES = 4,
  parameter int EXTRS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [NODE_IW-1:0] cfg_node,
  input  logic [3:0]         cfg_item,
  input  logic [31:0]        cfg_data,
  input  logic [NODE_IW-1:0] rd_node,
  output hp_node_t           node_o,
  output hp_match_t          match_o [MATCHES],
  output hp_extr_t           extr_o  [EXTRS]
);
  localparam int NODES      = 1 << NODE_IW;
  localparam int EXTR_ITEM0 = 8;

  hp_node_t  node_tab  [NODES];
  hp_match_t match_tab [NODES][MATCHES];
  hp_extr_t  extr_tab  [NODES][EXTRS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++) begin
        node_tab[n] <= '0;
        for (int m = 0; m < MATCHES; m++) match_tab[n][m] <= '0;
        for (int e = 0; e < EXTRS; e++) extr_tab[n][e] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_item == 4'd0) node_tab[cfg_node] <= word_to_node(cfg_data);
      for (int m = 0; m < MATCHES; m++)
        if (cfg_item == 4'(m + 1)) match_tab[cfg_node][m] <= word_to_match(cfg_data);
      for (int e = 0; e < EXTRS; e++)
        if (cfg_item == 4'(EXTR_ITEM0 + e)) extr_tab[cfg_node][e] <= word_to_extr(cfg_data);
    end
  end

  assign node_o = node_tab[rd_node];
  for (genvar m = 0; m < MATCHES; m++) begin : g_mrd
    assign match_o[m] = match_tab[rd_node][m];
  end
  for (genvar e = 0; e < EXTRS; e++) begin : g_erd
    assign extr_o[e] = extr_tab[rd_node][e];
  end
endmodule

// File: rtl/hp_walker.sv
module hp_walker
  import hp_pkg::*;
#(
  parameter int WIN     = 64,
  parameter int LEN_W   = 12,
  parameter int PORT_W  = 4,
  parameter int MATCHES = 4,
  parameter int EXTRS   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         start,
  input  logic [PORT_W-1:0]            port_in,
  input  logic [WIN*8-1:0]             win_flat,
  input  logic [LEN_W-1:0]             pkt_len,
  input  hp_node_t                     node,
  input  hp_match_t                    match [MATCHES],
  input  hp_extr_t                     extr  [EXTRS],
  output logic [NODE_IW-1:0]           cur_node,
  output logic                         busy,
  output logic                         step,
  output logic                         short_hdr,
  output logic                         out_valid,
  output logic                         out_err,
  output logic [PORT_W-1:0]            out_port,
  output logic [(1<<NODE_IW)-1:0]      out_hdr_vld,
  output logic [FIELD_W*(1<<SLOT_IW)-1:0] out_vec
);
  localparam int NODES = 1 << NODE_IW;
  localparam int SLOTS = 1 << SLOT_IW;
  localparam int OFF_W = 10;

  // Big-endian read of nb bytes at idx; bytes past the window read zero.
  function automatic logic [FIELD_W-1:0] field_at(input logic [WIN*8-1:0] w,
                                                  input logic [OFF_W-1:0] idx,
                                                  input logic [1:0] nb);
    logic [FIELD_W-1:0] r;
    r = '0;
    for (int b = 0; b < FIELD_W / 8; b++) begin
      if (b < int'(nb)) begin
        int p;
        p = int'(idx) + b;
        r = {r[FIELD_W-9:0], (p < WIN) ? w[p*8 +: 8] : 8'h00};
      end
    end
    return r;
  endfunction

  logic [OFF_W-1:0]   base_q;
  logic [NODE_IW-1:0] hops_q;
  logic [FIELD_W-1:0] vec_q [SLOTS];
  logic [OFF_W-1:0]   end_off;
  logic [FIELD_W-1:0] sel_val;
  logic               hit;
  logic [NODE_IW-1:0] nxt;
  logic               stop;

  assign end_off   = base_q + {2'b00, node.len};
  assign short_hdr = (int'(end_off) > int'(pkt_len)) || (int'(end_off) > WIN);
  assign sel_val   = field_at(win_flat, base_q + {2'b00, node.sel_off}, node.sel_bytes);
  assign step      = busy;

  always_comb begin
    hit = 1'b0;
    nxt = '0;
    for (int m = MATCHES - 1; m >= 0; m--) begin
      if (match[m].en && match[m].val == sel_val) begin
        hit = 1'b1;
        nxt = match[m].nxt;
      end
    end
  end

  assign stop = (node.sel_bytes == 2'd0) || !hit || (hops_q == NODE_IW'(NODES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_node    <= '0;
      base_q      <= '0;
      hops_q      <= '0;
      out_valid   <= 1'b0;
      out_err     <= 1'b0;
      out_port    <= '0;
      out_hdr_vld <= '0;
      for (int s = 0; s < SLOTS; s++) vec_q[s] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (clr) begin
        for (int s = 0; s < SLOTS; s++) vec_q[s] <= '0;
        out_hdr_vld <= '0;
        out_err     <= 1'b0;
        out_port    <= port_in;
      end
      if (start) begin
        busy     <= 1'b1;
        cur_node <= '0;
        base_q   <= '0;
        hops_q   <= '0;
      end else if (busy) begin
        if (short_hdr) begin
          out_err   <= 1'b1;
          busy      <= 1'b0;
          out_valid <= 1'b1;
        end else begin
          out_hdr_vld[cur_node] <= 1'b1;
          for (int e = 0; e < EXTRS; e++)
            if (extr[e].en)
              vec_q[extr[e].slot] <= field_at(win_flat, base_q + {2'b00, extr[e].off},
                                              extr[e].nbytes);
          if (stop) begin
            busy      <= 1'b0;
            out_valid <= 1'b1;
          end else begin
            cur_node <= nxt;
            base_q   <= end_off;
            hops_q   <= hops_q + 1'b1;
          end
        end
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_vec
    assign out_vec[s*FIELD_W +: FIELD_W] = vec_q[s];
  end
endmodule

// File: rtl/hdr_parser.sv
module hdr_parser
  import hp_pkg::*;
#(
  parameter int WIN     = 64,
  parameter int LEN_W   = 12,
  parameter int PORT_W  = 4,
  parameter int MATCHES = 4,
  parameter int EXTRS   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic                            in_sop,
  input  logic                            in_eop,
  input  logic [7:0]                      in_byte,
  input  logic [PORT_W-1:0]               in_port,
  output logic                            in_ready,
  input  logic                            cfg_we,
  input  logic [NODE_IW-1:0]              cfg_node,
  input  logic [3:0]                      cfg_item,
  input  logic [31:0]                     cfg_data,
  output logic                            out_valid,
  output logic                            out_err,
  output logic [PORT_W-1:0]               out_port,
  output logic [(1<<NODE_IW)-1:0]         out_hdr_vld,
  output logic [FIELD_W*(1<<SLOT_IW)-1:0] out_vec
);
  logic               in_pkt;
  logic               take;
  logic               acc_sop;
  logic               acc_eop;
  logic               busy;
  logic               wk_step;
  logic               wk_short;
  logic [NODE_IW-1:0] cur_node;
  logic [WIN*8-1:0]   win_flat;
  logic [LEN_W-1:0]   pkt_len;
  hp_node_t           node;
  hp_match_t          match [MATCHES];
  hp_extr_t           extr  [EXTRS];

  assign in_ready = !busy;
  assign take     = in_valid && in_ready && (in_sop || in_pkt);
  assign acc_sop  = in_valid && in_ready && in_sop;
  assign acc_eop  = take && in_eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    in_pkt <= 1'b0;
    else if (take) in_pkt <= !in_eop;
  end

  hp_byte_window #(.WIN(WIN), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(in_sop), .din(in_byte),
    .win_flat(win_flat), .pkt_len(pkt_len)
  );

  hp_graph_table #(.MATCHES(MATCHES), .EXTRS(EXTRS)) u_tab (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_node(cfg_node),
    .cfg_item(cfg_item), .cfg_data(cfg_data), .rd_node(cur_node),
    .node_o(node), .match_o(match), .extr_o(extr)
  );

  hp_walker #(.WIN(WIN), .LEN_W(LEN_W), .PORT_W(PORT_W), .MATCHES(MATCHES),
              .EXTRS(EXTRS)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(acc_sop), .start(acc_eop), .port_in(in_port),
    .win_flat(win_flat), .pkt_len(pkt_len), .node(node), .match(match), .extr(extr),
    .cur_node(cur_node), .busy(busy), .step(wk_step), .short_hdr(wk_short),
    .out_valid(out_valid), .out_err(out_err), .out_port(out_port),
    .out_hdr_vld(out_hdr_vld), .out_vec(out_vec)
  );
endmodule

// File: rtl/hdr_parser_chk.sv
module hdr_parser_chk #(
  parameter int NODES = 8,
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             acc_sop,
  input logic             acc_eop,
  input logic             wk_step,
  input logic             wk_short,
  input logic             out_valid,
  input logic             out_err,
  input logic [NODES-1:0] out_hdr_vld,
  input logic [VEC_W-1:0] out_vec
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= wk_step ? run_q + 1'b1 : 8'd0;
  end

  AST_SOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sop |=> (out_vec == '0 && out_hdr_vld == '0 && !out_err)); // R2
  AST_SHORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_step && wk_short) |=> (out_valid && out_err)); // R6
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    acc_eop |=> !in_ready); // R8
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R8
  AST_HOP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wk_step |-> (int'(run_q) < NODES)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !acc_sop) |=> ($stable(out_vec) && $stable(out_hdr_vld) && $stable(out_err))); // R10
endmodule

bind hdr_parser hdr_parser_chk #(
  .NODES(1 << hp_pkg::NODE_IW),
  .VEC_W(hp_pkg::FIELD_W * (1 << hp_pkg::SLOT_IW))
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .acc_sop(acc_sop),
  .acc_eop(acc_eop), .wk_step(wk_step), .wk_short(wk_short),
  .out_valid(out_valid), .out_err(out_err), .out_hdr_vld(out_hdr_vld),
  .out_vec(out_vec)
);

// File: tb/hdr_parser_test.sv
module hdr_parser_test;
  localparam int NN = 8;
  localparam int WINB = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]   in_byte = '0;
  logic [3:0]   in_port = '0;
  logic         in_ready;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_node = '0;
  logic [3:0]   cfg_item = '0;
  logic [31:0]  cfg_data = '0;
  logic         out_valid, out_err;
  logic [3:0]   out_port;
  logic [7:0]   out_hdr_vld;
  logic [255:0] out_vec;

  hdr_parser uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_byte(in_byte), .in_port(in_port), .in_ready(in_ready), .cfg_we(cfg_we),
    .cfg_node(cfg_node), .cfg_item(cfg_item), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_err(out_err), .out_port(out_port),
    .out_hdr_vld(out_hdr_vld), .out_vec(out_vec)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [255:0] vec;
    logic [7:0]   hv;
    logic         err;
    logic [3:0]   port;
    int           due;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int nchk = 0, nfail = 0, cyc = 0;
  logic [255:0] last_vec = '0;

  // bench copy of the graph table, filled from the R11 encoding
  int m_len[NN], m_soff[NN], m_sb[NN];
  int mt_val[NN][4], mt_nxt[NN][4]; bit mt_en[NN][4];
  int e_off[NN][4], e_nb[NN][4], e_slot[NN][4]; bit e_en[NN][4];

  logic [7:0] pk[80];
  int plen;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic [255:0] got, logic [255:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk("R7", "unexpected strobe", 1, 0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(x.tag, "vector", out_vec, x.vec);
        chk("R5", "header bitmap", out_hdr_vld, x.hv);
        chk("R6", "error flag", out_err, x.err);
        chk("R2", "port", out_port, x.port);
        chk("R7", "strobe cycle", cyc, x.due);
        last_vec = out_vec;
      end
    end
  end

  task automatic set_cfg(int n, int it, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_node = 3'(n); cfg_item = 4'(it); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (it == 0) begin
      m_len[n] = d[7:0]; m_soff[n] = d[15:8]; m_sb[n] = d[17:16];
    end else if (it >= 1 && it <= 4) begin
      mt_val[n][it-1] = d[15:0]; mt_nxt[n][it-1] = d[18:16]; mt_en[n][it-1] = d[31];
    end else if (it >= 8 && it <= 11) begin
      e_off[n][it-8] = d[7:0]; e_nb[n][it-8] = d[9:8];
      e_slot[n][it-8] = d[19:16]; e_en[n][it-8] = d[31];
    end
  endtask

  function automatic int byte_at(int i);
    return (i < plen && i < WINB) ? int'(pk[i]) : 0;
  endfunction

  function automatic int fld(int i, int nb);
    if (nb == 0) return 0;
    if (nb == 1) return byte_at(i);
    return byte_at(i) * 256 + byte_at(i + 1);
  endfunction

  // walk of the bench's own graph copy, per R3..R9
  task automatic predict(ref exp_t x, output int lat);
    int base = 0, cur = 0, hops = 0;
    lat = 0; x.vec = '0; x.hv = '0; x.err = 1'b0;
    while (1) begin
      int endo, sel, nx;
      bit found;
      lat++;
      endo = base + m_len[cur];
      if (endo > plen || endo > WINB) begin x.err = 1'b1; break; end
      x.hv[cur] = 1'b1;
      for (int e = 0; e < 4; e++)
        if (e_en[cur][e]) x.vec[e_slot[cur][e]*16 +: 16] = 16'(fld(base + e_off[cur][e], e_nb[cur][e]));
      if (m_sb[cur] == 0) break;
      sel = fld(base + m_soff[cur], m_sb[cur]);
      found = 0; nx = 0;
      for (int m = 0; m < 4; m++)
        if (!found && mt_en[cur][m] && mt_val[cur][m] == sel) begin found = 1; nx = mt_nxt[cur][m]; end
      if (!found || hops == NN - 1) break;
      cur = nx; base = endo; hops++;
    end
  endtask

  task automatic send(int port, string tag, bit poke);
    exp_t x;
    int lat, c;
    x.port = 4'(port); x.tag = tag;
    predict(x, lat);
    while (!in_ready) @(negedge clk);
    c = cyc;
    x.due = c + plen + lat;
    sb.push_back(x);
    for (int i = 0; i < plen; i++) begin
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == plen - 1);
      in_byte = pk[i]; in_port = 4'(port);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    if (poke) begin
      chk("R8", "in_ready after end byte", in_ready, 0);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_byte = 8'hEE; in_port = 4'hF;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    end
  endtask

  task automatic fill(int n);
    plen = n;
    for (int i = 0; i < 80; i++) pk[i] = 8'((i * 7 + 3) & 8'hFF);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < NN; n++) begin
      m_len[n] = 0; m_soff[n] = 0; m_sb[n] = 0;
      for (int k = 0; k < 4; k++) begin
        mt_val[n][k] = 0; mt_nxt[n][k] = 0; mt_en[n][k] = 0;
        e_off[n][k] = 0; e_nb[n][k] = 0; e_slot[n][k] = 0; e_en[n][k] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "out_vec", out_vec, 0);
    chk("R1", "out_hdr_vld", out_hdr_vld, 0);
    chk("R1", "out_err", out_err, 0);

    // R11: graph for link, ipv4, label stack, transport, loop node
    set_cfg(0, 0, 32'h0002_0C0E); set_cfg(0, 1, 32'h8001_0800);
    set_cfg(0, 2, 32'h8002_8847); set_cfg(0, 3, 32'h8004_9999);
    set_cfg(0, 8, 32'h8000_0200); set_cfg(0, 9, 32'h8001_020C);
    set_cfg(1, 0, 32'h0001_0914); set_cfg(1, 1, 32'h8003_0006);
    set_cfg(1, 8, 32'h8002_0108); set_cfg(1, 9, 32'h8003_020C);
    set_cfg(2, 0, 32'h0001_0204); set_cfg(2, 1, 32'h8005_0000);
    set_cfg(2, 2, 32'h8001_0001); set_cfg(2, 8, 32'h8004_0200);
    set_cfg(5, 0, 32'h0001_0204); set_cfg(5, 1, 32'h8001_0001);
    set_cfg(5, 8, 32'h8005_0200);
    set_cfg(3, 0, 32'h0000_0014); set_cfg(3, 8, 32'h8006_0200);
    set_cfg(3, 9, 32'h8007_0202);
    set_cfg(4, 0, 32'h0001_0102); set_cfg(4, 1, 32'h8004_0055);
    set_cfg(4, 8, 32'h8008_0100);
    set_cfg(6, 8, 32'h8009_0100);

    // R3: link + ipv4 + transport, with stray byte while busy (R8)
    fill(54); pk[12] = 8'h08; pk[13] = 8'h00; pk[23] = 8'd6;
    send(3, "R3", 1);
    // R4: two stacked labels, then ipv4 with unmatched protocol
    fill(42); pk[12] = 8'h88; pk[13] = 8'h47; pk[16] = 8'h00; pk[20] = 8'h01; pk[31] = 8'd17;
    send(5, "R4", 0);
    // R3: one label, ipv4, transport
    fill(58); pk[12] = 8'h88; pk[13] = 8'h47; pk[16] = 8'h01; pk[27] = 8'd6;
    send(7, "R3", 1);
    // R4: unknown type stops after the first header
    fill(20); pk[12] = 8'h12; pk[13] = 8'h34;
    send(1, "R4", 0);
    // R6 / R2: ipv4 cut short, earlier slots must be gone
    fill(30); pk[12] = 8'h08; pk[13] = 8'h00;
    send(2, "R6", 0);
    // R6: shorter than the first header
    fill(10);
    send(4, "R6", 0);
    // R6: single-byte packet
    fill(1);
    send(6, "R6", 1);
    // R9: looping graph ends after NN nodes
    fill(40); pk[12] = 8'h99; pk[13] = 8'h99;
    for (int k = 0; k < 13; k++) pk[15 + 2*k] = 8'h55;
    send(8, "R9", 0);
    drain();
    // R10: outputs hold while idle
    repeat (6) @(negedge clk);
    chk("R10", "held vector", out_vec, last_vec);
    // R11 / R4: lower entry wins, then disabling it redirects
    set_cfg(0, 4, 32'h8006_0800);
    fill(54); pk[12] = 8'h08; pk[13] = 8'h00; pk[23] = 8'd6;
    send(9, "R4", 0);
    drain();
    set_cfg(0, 1, 32'h0000_0000);
    send(10, "R11", 0);
    drain();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule